// File: doc/BRIEF.md
# Register-ALU Datapath with Carry Flag

A narrow datapath for a small processor core: two operand registers (A and B), a combinational ALU between them, a result register and a one-bit carry flag. Each register bit is a D flip-flop behind a two-input multiplexer. The multiplexer takes new data when that register's load enable is high and keeps its own output otherwise. One free-running clock drives every flop, and the clock is never gated.

A mode bit picks arithmetic or logic operations, and a 4-bit select code picks the operation within that mode. The ALU output is captured on the next clock edge into the result register. When write-back is asserted, the output goes back into the A register instead. Write-back is how a one-cycle "complement A" instruction works: A feeds the ALU, the logic-mode complement code is applied, and A reloads on the next edge. Arithmetic operations also capture the adder carry-out into the carry flag. Logic operations leave the carry flag unchanged.

Top module: `regalu_dp`

## Requirements
- R1: While `rst_ni` is low, A, B, the result and the carry read zero, and this does not wait for a clock edge.
- R2: With `clr_i` high at a clock edge, every register and the carry are zero after that edge, and all loads in that cycle are ignored.
- R3: A, B and the result each take new data only at an edge where their load enable is high. The load enables are `a_ld_i`/`wb_i`, `b_ld_i` and `res_ld_i`. Otherwise each register keeps its value.
- R4: With `mode_i`=0 and `sel_i`=4'b0010 (add), the next edge with `res_ld_i` high stores (A+B) mod 16 in the result register and bit 4 of A+B in the carry.
- R5: With `mode_i`=0 and `sel_i`=4'b0011 (subtract), the stored result is A+~B+1 mod 16, and the carry is the carry-out of that sum, which is 1 exactly when A>=B.
- R6: With `mode_i`=0 and any other select code, the ALU passes A through with a carry-out of 0.
- R7: With `mode_i`=1 and `sel_i`=4'b0000, the ALU output is the bitwise complement of A.
- R8: With `mode_i`=1, select 4'b0001 gives A AND B, 4'b0010 gives A OR B, 4'b0011 gives A XOR B, and any other code passes A through.
- R9: In logic mode the carry keeps its value at every edge unless `clr_i` is high. In arithmetic mode the carry is updated at an edge where `res_ld_i` or `wb_i` is high.
- R10: With `wb_i` high, A reloads from the ALU output at the next edge, taking priority over `a_ld_i`. The result register is unaffected unless `res_ld_i` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high |
| a_ld_i | input | 1 | Load A from `a_d_i` |
| a_d_i | input | 4 | External data for A |
| b_ld_i | input | 1 | Load B from `b_d_i` |
| b_d_i | input | 4 | External data for B |
| mode_i | input | 1 | 0 = arithmetic, 1 = logic |
| sel_i | input | 4 | Operation select code |
| res_ld_i | input | 1 | Capture the ALU output into the result register |
| wb_i | input | 1 | Write the ALU output back into A |
| a_o | output | 4 | A register |
| b_o | output | 4 | B register |
| res_o | output | 4 | Result register |
| carry_o | output | 1 | Carry flag |

## Verification
Every register sits one edge after its inputs. An operation set up before an edge appears on `res_o`, `carry_o` or `a_o` right after that edge, and operands loaded at an edge are used at the following one. Inputs are driven on the falling edge. The behavioural model advances on each rising edge, and every output is compared with it on the next falling edge, so the check always falls one edge after the stimulus. Each operation is applied to all 256 operand pairs. Clears, hold cycles, write-back and a mid-run asynchronous reset are interleaved with these runs.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  localparam int unsigned DW = 4;
  localparam int unsigned SW = 4;

  // arithmetic codes (mode 0)
  localparam logic [SW-1:0] ARI_ADD  = 4'b0010;
  localparam logic [SW-1:0] ARI_SUB  = 4'b0011;
  // logic codes (mode 1)
  localparam logic [SW-1:0] LOG_NOTA = 4'b0000;
  localparam logic [SW-1:0] LOG_AND  = 4'b0001;
  localparam logic [SW-1:0] LOG_OR   = 4'b0010;
  localparam logic [SW-1:0] LOG_XOR  = 4'b0011;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // per-bit mux-in-front-of-flop, no clock gating
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    assign nxt = ld_i ? d_i[i] : q_o[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[i] <= 1'b0;
      else if (clr_i) q_o[i] <= 1'b0;
      else            q_o[i] <= nxt;
    end
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i) |=> $stable(q_o)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0)); // R2
endmodule

// File: rtl/alu_core.sv
module alu_core
  import regalu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic          mode_i,
  input  logic [SW-1:0] sel_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  f_o,
  output logic          cout_o
);
  logic [W:0] sum;

  always_comb begin
    sum    = '0;
    f_o    = a_i;
    cout_o = 1'b0;
    if (mode_i) begin
      unique case (sel_i)
        LOG_NOTA: f_o = ~a_i;
        LOG_AND:  f_o = a_i & b_i;
        LOG_OR:   f_o = a_i | b_i;
        LOG_XOR:  f_o = a_i ^ b_i;
        default:  f_o = a_i;
      endcase
    end else begin
      unique case (sel_i)
        ARI_ADD: sum = {1'b0, a_i} + {1'b0, b_i};
        ARI_SUB: sum = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
        default: sum = {1'b0, a_i};
      endcase
      f_o    = sum[W-1:0];
      cout_o = sum[W];
    end
  end
endmodule

// File: rtl/regalu_dp.sv
module regalu_dp
  import regalu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          a_ld_i,
  input  logic [DW-1:0] a_d_i,
  input  logic          b_ld_i,
  input  logic [DW-1:0] b_d_i,
  input  logic          mode_i,
  input  logic [SW-1:0] sel_i,
  input  logic          res_ld_i,
  input  logic          wb_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  logic [DW-1:0] alu_f;
  logic          alu_c;
  logic [DW-1:0] a_new;
  logic          a_ld;
  logic          c_ld;

  // write-back outranks the external load
  assign a_new = wb_i ? alu_f : a_d_i;
  assign a_ld  = wb_i | a_ld_i;
  assign c_ld  = (res_ld_i | wb_i) & ~mode_i;

  dp_reg #(.W(DW)) u_a (
    .clk_i, .rst_ni, .clr_i, .ld_i(a_ld), .d_i(a_new), .q_o(a_o)
  );
  dp_reg #(.W(DW)) u_b (
    .clk_i, .rst_ni, .clr_i, .ld_i(b_ld_i), .d_i(b_d_i), .q_o(b_o)
  );
  dp_reg #(.W(DW)) u_res (
    .clk_i, .rst_ni, .clr_i, .ld_i(res_ld_i), .d_i(alu_f), .q_o(res_o)
  );
  dp_reg #(.W(1)) u_cy (
    .clk_i, .rst_ni, .clr_i, .ld_i(c_ld), .d_i(alu_c), .q_o(carry_o)
  );

  alu_core #(.W(DW)) u_alu (
    .mode_i, .sel_i, .a_i(a_o), .b_i(b_o), .f_o(alu_f), .cout_o(alu_c)
  );

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (a_o == '0 && b_o == '0 && res_o == '0 && !carry_o)); // R1
  AST_ADD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && res_ld_i && !mode_i && sel_i == ARI_ADD) |=>
      ({carry_o, res_o} == ({1'b0, $past(a_o)} + {1'b0, $past(b_o)}))); // R4
  AST_COMPA_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wb_i && mode_i && sel_i == LOG_NOTA) |=> (a_o == ~$past(a_o))); // R7
  AST_LOGIC_CARRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && mode_i) |=> $stable(carry_o)); // R9
  AST_WB_RES_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wb_i && !res_ld_i) |=> $stable(res_o)); // R10
endmodule

// File: tb/sim_regalu_dp.sv
module sim_regalu_dp;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       a_ld_i = 1'b0, b_ld_i = 1'b0;
  logic [3:0] a_d_i = '0, b_d_i = '0;
  logic       mode_i = 1'b0;
  logic [3:0] sel_i = '0;
  logic       res_ld_i = 1'b0, wb_i = 1'b0;
  logic [3:0] a_o, b_o, res_o;
  logic       carry_o;

  int n_run = 0, n_fail = 0;
  int m_a = 0, m_b = 0, m_res = 0, m_c = 0;

  always #4 clk_i = ~clk_i;

  regalu_dp u0 (.*);

  // returns {carry, f} as an integer
  function automatic int ref_op(bit m, int s, int a, int b);
    if (m) begin
      case (s)
        0: return (~a) & 15;
        1: return a & b;
        2: return a | b;
        3: return a ^ b;
        default: return a;
      endcase
    end
    case (s)
      2: return a + b;
      3: return a + (15 - b) + 1;
      default: return a;
    endcase
  endfunction

  task automatic check(string tag);
    n_run++;
    if (a_o !== m_a[3:0] || b_o !== m_b[3:0] || res_o !== m_res[3:0] || carry_o !== m_c[0]) begin
      n_fail++;
      $display("FAIL %s: a/b/res/c act %h/%h/%h/%b exp %h/%h/%h/%b", tag,
               a_o, b_o, res_o, carry_o, m_a[3:0], m_b[3:0], m_res[3:0], m_c[0]);
    end
  endtask

  // inputs set at negedge; model advances at posedge; compare at next negedge
  task automatic cyc(string tag);
    int r;
    @(posedge clk_i);
    r = ref_op(mode_i, int'(sel_i), m_a, m_b);
    if (clr_i) begin
      m_a = 0; m_b = 0; m_res = 0; m_c = 0;
    end else begin
      if (res_ld_i) m_res = r & 15;
      if ((res_ld_i || wb_i) && !mode_i) m_c = (r >> 4) & 1;
      if (wb_i) m_a = r & 15;
      else if (a_ld_i) m_a = int'(a_d_i);
      if (b_ld_i) m_b = int'(b_d_i);
    end
    @(negedge clk_i);
    check(tag);
    {clr_i, a_ld_i, b_ld_i, res_ld_i, wb_i} = '0;
  endtask

  function automatic string op_tag(bit m, int s);
    if (!m) return (s == 2) ? "R4 add" : (s == 3) ? "R5 sub" : "R6 pass";
    return (s == 0) ? "R7 not" : "R8 logic";
  endfunction

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: act timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    for (int op = 0; op < 7; op++) begin
      bit m = (op >= 3);
      int s = (op == 0) ? 2 : (op == 1) ? 3 : (op == 2) ? 9 : op - 3;
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          a_d_i = 4'(a); b_d_i = 4'(b); a_ld_i = 1; b_ld_i = 1;
          mode_i = m; sel_i = 4'(s);
          cyc("R3 load");
          res_ld_i = 1;
          cyc(op_tag(m, s));
        end
      end
    end

    // logic op must keep carry: set carry via add, then logic ops
    a_d_i = 4'hF; b_d_i = 4'h1; a_ld_i = 1; b_ld_i = 1; mode_i = 0; sel_i = 4'b0010;
    cyc("R3 load");
    res_ld_i = 1; cyc("R4 carry set");
    mode_i = 1; sel_i = 4'b0010; res_ld_i = 1; cyc("R9 logic keeps carry");
    wb_i = 1; sel_i = 4'b0011; cyc("R9 logic wb keeps carry");

    // hold: no loads, operands change on pins
    a_d_i = 4'h5; b_d_i = 4'hA; mode_i = 0; sel_i = 4'b0011;
    cyc("R3 hold");
    cyc("R3 hold");

    // complement-A write-back, priority over external load
    a_d_i = 4'h6; a_ld_i = 1; cyc("R3 load");
    mode_i = 1; sel_i = 4'b0000; wb_i = 1; a_d_i = 4'h3; a_ld_i = 1;
    cyc("R10 wb priority R7");
    wb_i = 1; cyc("R7 compA twice");
    // arithmetic write-back updates carry, result untouched
    b_d_i = 4'hC; b_ld_i = 1; cyc("R3 load");
    mode_i = 0; sel_i = 4'b0010; wb_i = 1; cyc("R10 wb add");
    sel_i = 4'b0011; wb_i = 1; res_ld_i = 1; cyc("R10 wb+res sub");

    // sync clear beats loads
    a_d_i = 4'h9; a_ld_i = 1; b_ld_i = 1; res_ld_i = 1; clr_i = 1;
    cyc("R2 clear");

    // async reset mid-run
    a_d_i = 4'h7; a_ld_i = 1; cyc("R3 load");
    #1 rst_ni = 1'b0;
    #1;
    m_a = 0; m_b = 0; m_res = 0; m_c = 0;
    check("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc("R1 idle after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule